// File: doc/BRIEF.md
# Game Pad Serial Input Controller

This block sits between a game pad's sampled 16-bit key word and a processor. The processor sees one 8-bit control/status register and two 8-bit data registers, one holding the low key byte and one holding the high key byte. A single control write can start a timed capture. When the capture ends, both data registers take the key word, and a level interrupt may be raised. As a second way to read the pad, the processor can clock the capture itself: it arms a step counter, then toggles a clock bit in successive control writes until the counter runs out, and at that point the key word is latched.

Several actions can come from one control write. They are resolved in a fixed order: interrupt inhibit and acknowledge first, then disable and abort, then the start of a timed capture, then arming the software capture, and last the software clock step. Each stage sees the result of the stages before it. The interrupt stays asserted until software acknowledges it by writing the inhibit bit.

Top module: `pad_sio_ctrl`

## Requirements
- R1: After reset the control register reads 0x4C, both data registers read 0x00, and the interrupt output is 0.
- R2: The control register reads bit7 = inhibit, bit5 = software-capture arm, bit4 = software clock and bit0 = disable, each as last written. Bit1 reads as timed capture busy. Bits 6, 3 and 2 always read 1.
- R3: A write with bit2 = 1 and bit0 = 0 while idle starts a timed capture. Busy then reads 1 in exactly HW_CYCLES consecutive cycles, beginning with the cycle after the write edge. The default is 10240 cycles.
- R4: When a timed capture completes, the low data register holds key bits 7:0 and the high data register holds key bits 15:8. At all other times the data registers change only when a software capture completes.
- R5: On completion of a timed capture, the interrupt is raised only when inhibit is 0, at least one key bit in 15:4 is 1, and key bits 3:1 are all 0.
- R6: Once raised, the interrupt stays at 1 through writes with bit7 = 0. A write with bit7 = 1 sets inhibit and clears the interrupt.
- R7: A write with bit0 = 1 sets disable and cancels a timed capture in progress. A capture cancelled in its final cycle latches no data and raises no interrupt.
- R8: A start write while a timed capture is busy is ignored, and the capture ends at its original time.
- R9: A write with bit5 = 1 while no timed capture is busy arms the software step counter at 32. The same write while busy does not arm it. Starting a timed capture cancels any software capture in progress.
- R10: Each write with bit5 = 0 decrements a nonzero step counter when the written bit4 differs from bit 0 of the step count. When the count reaches 0, both data registers latch the key word. After arming, 32 writes alternating bit4 = 1, 0, … complete the capture, and a repeated bit4 value does not advance it.
- R11: Within one write the effects apply in order. A write of 0x05 starts nothing because disable is applied first. A write of 0x24 starts a timed capture and does not arm the software counter.
- R12: A write with bit7 = 1 in the final cycle of a timed capture still lets the data latch, and it suppresses the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control register write strobe, one cycle per write |
| wr_data | input | 8 | Control write value |
| keys | input | 16 | Parallel key word from the pad |
| ctrl_rd | output | 8 | Control/status register read value |
| lo_rd | output | 8 | Low data register |
| hi_rd | output | 8 | High data register |
| irq | output | 1 | Pad interrupt, level |

## Verification
Two functions can land in the same cycle: a control write, and the completion of the countdown of a timed capture. The bench starts a capture, then counts HW_CYCLES−1 falling edges, so that its next write hits the exact edge on which the count runs out. It does this once with an abort write and once with an inhibit write. With the abort it expects the old data to remain and no interrupt. With the inhibit it expects the new key word to be latched and the interrupt to stay at 0. The same write-ordering conflict inside a single write (0x05, 0x24) is judged through the busy bit and through a later software capture that must not latch.

// File: rtl/pad_sio_pkg.sv
package pad_sio_pkg;
  localparam int KeyW       = 16;
  localparam int CtlInhibit = 7;
  localparam int CtlSwArm   = 5;
  localparam int CtlSwClk   = 4;
  localparam int CtlStart   = 2;
  localparam int CtlBusy    = 1;
  localparam int CtlDisable = 0;
  localparam logic [7:0] CtlOnes = 8'h4C;

  function automatic logic irq_qualify(input logic [KeyW-1:0] k);
    return (|k[KeyW-1:4]) && (k[3:1] == 3'b000);
  endfunction
endpackage

// File: rtl/pad_sio_timer.sv
module pad_sio_timer #(
  parameter int HW_CYCLES = 10240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(HW_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) && !abort;

  always_comb begin
    cnt_d = cnt_q;
    if (abort)      cnt_d = '0;
    else if (start) cnt_d = CW'(HW_CYCLES);
    else if (busy)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
  a_r3_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(HW_CYCLES));
endmodule

// File: rtl/pad_sio_stepper.sv
module pad_sio_stepper #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic reload,
  input  logic adv_en,
  input  logic clk_bit,
  output logic done
);
  localparam int SW = $clog2(STEPS + 1);

  logic [SW-1:0] step_q, step_d, step_a;
  logic          advance;

  always_comb begin
    step_a  = clear ? '0 : step_q;
    advance = adv_en && (step_a != '0) && (clk_bit ^ step_a[0]);
    done    = advance && (step_a == SW'(1));
    step_d  = step_a;
    if (reload)       step_d = SW'(STEPS);
    else if (advance) step_d = step_a - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  a_r9_arm_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (step_q == SW'(STEPS)));
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !clear) |=> (step_q == $past(step_q) || step_q == $past(step_q) - SW'(1)));
endmodule

// File: rtl/pad_sio_ctrl.sv
module pad_sio_ctrl
  import pad_sio_pkg::*;
#(
  parameter int HW_CYCLES = 10240,
  parameter int SW_STEPS  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic [KeyW-1:0] keys,
  output logic [7:0]      ctrl_rd,
  output logic [7:0]      lo_rd,
  output logic [7:0]      hi_rd,
  output logic            irq
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic inhibit_q, arm_q, swclk_q, disable_q, irq_q;
  logic inhibit_d, arm_d, swclk_d, disable_d, irq_d;
  logic [7:0] lo_q, hi_q, lo_d, hi_d;
  logic abort, start, busy, busy_mid, reload, adv_en;
  logic hw_done, sw_done, latch;
  logic unused_bits;

  assign unused_bits = ^{wr_data[6], wr_data[3], wr_data[1]};

  always_comb begin
    inhibit_d = wr_en ? wr_data[CtlInhibit] : inhibit_q;
    disable_d = wr_en ? wr_data[CtlDisable] : disable_q;
    arm_d     = wr_en ? wr_data[CtlSwArm]   : arm_q;
    swclk_d   = wr_en ? wr_data[CtlSwClk]   : swclk_q;
    abort     = wr_en && wr_data[CtlDisable];
    start     = wr_en && wr_data[CtlStart] && !busy && !disable_d;
    busy_mid  = start || (busy && !abort);
    reload    = wr_en && wr_data[CtlSwArm] && !busy_mid;
    adv_en    = wr_en && !wr_data[CtlSwArm];
  end

  pad_sio_timer #(.HW_CYCLES(HW_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_q_n), .start(start), .abort(abort),
    .busy(busy), .done(hw_done)
  );

  pad_sio_stepper #(.STEPS(SW_STEPS)) u_stepper (
    .clk(clk), .rst_n(rst_q_n), .clear(start), .reload(reload),
    .adv_en(adv_en), .clk_bit(wr_data[CtlSwClk]), .done(sw_done)
  );

  assign latch = hw_done || sw_done;

  always_comb begin
    lo_d  = latch ? keys[7:0]  : lo_q;
    hi_d  = latch ? keys[15:8] : hi_q;
    irq_d = irq_q && !(wr_en && wr_data[CtlInhibit]);
    if (hw_done && !inhibit_d && irq_qualify(keys)) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      inhibit_q <= 1'b0;
      arm_q     <= 1'b0;
      swclk_q   <= 1'b0;
      disable_q <= 1'b0;
      irq_q     <= 1'b0;
      lo_q      <= 8'h00;
      hi_q      <= 8'h00;
    end else begin
      inhibit_q <= inhibit_d;
      arm_q     <= arm_d;
      swclk_q   <= swclk_d;
      disable_q <= disable_d;
      irq_q     <= irq_d;
      lo_q      <= lo_d;
      hi_q      <= hi_d;
    end
  end

  always_comb begin
    ctrl_rd             = CtlOnes;
    ctrl_rd[CtlInhibit] = inhibit_q;
    ctrl_rd[CtlSwArm]   = arm_q;
    ctrl_rd[CtlSwClk]   = swclk_q;
    ctrl_rd[CtlBusy]    = busy;
    ctrl_rd[CtlDisable] = disable_q;
  end

  assign lo_rd = lo_q;
  assign hi_rd = hi_q;
  assign irq   = irq_q;

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_data[CtlInhibit]) |=> !irq);
  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(irq) |-> $past(hw_done));
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !latch |=> $stable({hi_q, lo_q}));
  a_r11_no_start_when_disabled: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_data[CtlDisable]) |=> !busy);
endmodule

// File: tb/tb_pad_sio_ctrl.sv
module tb_pad_sio_ctrl;
  localparam int HW = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [15:0] keys;
  logic [7:0]  ctrl_rd, lo_rd, hi_rd;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pad_sio_ctrl #(.HW_CYCLES(HW), .SW_STEPS(32)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .keys(keys),
    .ctrl_rd(ctrl_rd), .lo_rd(lo_rd), .hi_rd(hi_rd), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic do_write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (ctrl_rd[1] && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic toggles(input int from, input int upto);
    for (int i = from; i < upto; i++) do_write((i % 2 == 0) ? 8'h10 : 8'h00);
  endtask

  function automatic logic qual(input logic [15:0] k);
    return (k[15:4] != 12'h000) && (k[3:1] == 3'b000);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [11:0] uppers [4];
    logic [15:0] k;
    uppers[0] = 12'h000; uppers[1] = 12'h001; uppers[2] = 12'h800; uppers[3] = 12'h5A3;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; keys = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ctrl", ctrl_rd, 8'h4C);
    check("R1 data", {hi_rd, lo_rd}, 16'h0000);
    check("R1 irq", irq, 1'b0);

    do_write(8'h90); check("R2 inhibit+clk", ctrl_rd, 8'hDC);
    do_write(8'h31); check("R2 arm+clk+disable", ctrl_rd, 8'h7D);
    do_write(8'h00); check("R2 cleared", ctrl_rd, 8'h4C);

    // near-exhaustive sweep: low nibble x upper patterns
    for (int u = 0; u < 4; u++) begin
      for (int l = 0; l < 16; l++) begin
        k = {uppers[u], l[3:0]};
        keys = k;
        do_write(8'h04);
        wait_idle(n);
        check("R3 busy length", n, HW);
        check("R4 data", {hi_rd, lo_rd}, k);
        check("R5 irq", irq, qual(k));
        if (irq) begin
          do_write(8'h00); check("R6 irq held", irq, 1'b1);
          do_write(8'h80); check("R6 ack", irq, 1'b0);
          do_write(8'h00);
        end
      end
    end

    // R8 restart ignored
    keys = 16'h1234;
    do_write(8'h04);
    repeat (5) @(negedge clk);
    do_write(8'h04);
    wait_idle(n);
    check("R8 original end", n, HW - 6);
    check("R8 data", {hi_rd, lo_rd}, 16'h1234);

    // R7 abort mid-way
    keys = 16'h00F0;
    do_write(8'h04);
    repeat (3) @(negedge clk);
    do_write(8'h01);
    check("R7 abort ctrl", ctrl_rd, 8'h4D);
    repeat (HW + 5) @(negedge clk);
    check("R7 no latch", {hi_rd, lo_rd}, 16'h1234);
    check("R7 no irq", irq, 1'b0);
    do_write(8'h05); check("R11 disable before start", ctrl_rd, 8'h4D);
    do_write(8'h00);

    // R7 abort in the completion cycle
    keys = 16'h0010;
    do_write(8'h04);
    repeat (HW - 1) @(negedge clk);
    do_write(8'h01);
    check("R7 final-cycle abort data", {hi_rd, lo_rd}, 16'h1234);
    check("R7 final-cycle abort irq", irq, 1'b0);
    check("R7 final-cycle abort busy", ctrl_rd[1], 1'b0);
    do_write(8'h00);

    // R12 inhibit in the completion cycle
    do_write(8'h04);
    repeat (HW - 1) @(negedge clk);
    do_write(8'h80);
    check("R12 data latched", {hi_rd, lo_rd}, 16'h0010);
    check("R12 irq suppressed", irq, 1'b0);
    do_write(8'h00);
    repeat (3) @(negedge clk);
    check("R12 irq stays low", irq, 1'b0);

    // R10 software capture with a repeated clock value
    keys = 16'hBEEF;
    do_write(8'h20); check("R10 armed ctrl", ctrl_rd, 8'h6C);
    for (int i = 0; i < 32; i++) begin
      if (i == 10) do_write(8'h00);
      do_write((i % 2 == 0) ? 8'h10 : 8'h00);
      if (i == 30) check("R10 not yet latched", {hi_rd, lo_rd}, 16'h0010);
    end
    check("R10 latched", {hi_rd, lo_rd}, 16'hBEEF);
    keys = 16'h0BAD;
    do_write(8'h10);
    check("R10 idle after done", {hi_rd, lo_rd}, 16'hBEEF);

    // R9 timed start cancels software capture
    keys = 16'h1111;
    do_write(8'h20);
    toggles(0, 10);
    keys = 16'h2222;
    do_write(8'h04);
    wait_idle(n);
    check("R9 timed data", {hi_rd, lo_rd}, 16'h2222);
    keys = 16'h3333;
    toggles(10, 32);
    check("R9 cancelled", {hi_rd, lo_rd}, 16'h2222);

    // R9 arm ignored while busy
    do_write(8'h04);
    repeat (2) @(negedge clk);
    do_write(8'h20);
    wait_idle(n);
    check("R9 busy data", {hi_rd, lo_rd}, 16'h3333);
    keys = 16'h4444;
    toggles(0, 32);
    check("R9 arm ignored", {hi_rd, lo_rd}, 16'h3333);

    // R11 start then arm in one write
    do_write(8'h24);
    check("R11 0x24 ctrl", ctrl_rd, 8'h6E);
    wait_idle(n);
    check("R11 0x24 length", n, HW);
    keys = 16'h5555;
    toggles(0, 32);
    check("R11 no arm", {hi_rd, lo_rd}, 16'h4444);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule